// File: doc/BRIEF.md
# Bus-Mapped General-Purpose I/O Port

This block is a general-purpose I/O port that hangs off a simple single-cycle register bus. The number of I/O lines equals the register width. Each line has an output latch bit, a direction bit and a synchronised input sample. Software can load the whole output latch at once. It can also change individual latch bits without a read-modify-write sequence, through a write-one-to-set word and a write-one-to-clear word. The port drives a tri-state pad per line through separate level and enable outputs.

Two elaboration-time parameters adapt the port to the software that uses it. The first chooses the meaning of a direction bit of 1: output, or input. The second chooses mirrored bit order, where line 0 lives in the most significant register bit. Pad inputs pass through a two-flop synchroniser before software can read them. Reads are combinational from the current address, so read data is valid in the same cycle as the address.

Top module: `gpio_port_ctrl`

## Requirements
- R1: The register width, and so the line count, is set by the parameter WIDTH. The supported values are 8, 16, 32 and 64.
- R2: After a synchronous active-low reset, the output latch is all zeros and every pad output enable is 0. The direction word reads all zeros when DIR_IS_OUTPUT=1 and all ones when DIR_IS_OUTPUT=0.
- R3: A write to word offset 0 (port value) loads the entire output latch from the write data. pad_out shows the new value after that clock edge.
- R4: A write to word offset 1 (set word) forces to 1 every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value.
- R5: A write to word offset 2 (clear word) forces to 0 every latch bit whose write-data bit is 1. Latch bits whose write-data bit is 0 keep their value. When a set and a clear hit the same bit in one update, the clear wins.
- R6: A read of word offset 1 returns the output latch, so the driven level of each line can be read back.
- R7: A read of word offset 0 returns the pad levels through a two-flop synchroniser. A pad change made before clock edge k is visible in read data after edge k+1, and not after edge k.
- R8: Word offset 3 holds the direction word and reads back as written. With DIR_IS_OUTPUT=1, a direction bit of 1 enables that line's pad driver. With DIR_IS_OUTPUT=0, a direction bit of 0 enables it.
- R9: With MIRROR=1, line n corresponds to register bit WIDTH-1-n in every word, both for reads and for writes. With MIRROR=0, line n is register bit n.
- R10: Reads of the clear word and of any offset above 3 return zero. Writes to offsets above 3 change neither the latch nor the direction word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | WIDTH | Write data in register bit order |
| bus_rdata | output | WIDTH | Read data for bus_addr, combinational |
| pad_in | input | WIDTH | Pad input levels, indexed by line |
| pad_out | output | WIDTH | Pad drive levels, indexed by line |
| pad_oe | output | WIDTH | Pad driver enables, indexed by line |

## Verification
A corrupted output latch shows up on pad_out on the clock edge after the faulty update. It also shows up immediately on a readback of the set word. A corrupted direction bit shows on pad_oe in the same way, and the polarity parameter decides whether that bit should read as a 1 or a 0. A synchroniser that is one stage short or one stage long shifts the edge at which a new pad level appears in the port-value read by exactly one cycle, so the bench samples both the edge before the change and the edge of the change. A bit-order error moves a single-line pattern to the opposite end of the word, and a single-bit write exposes it at once.

// File: rtl/gpio_port_pkg.sv
// Package gpio_port_pkg
// Holds the word offsets of the port registers, shared by the register file
// and the bench-facing top. It assumes offsets are counted in whole words.
package gpio_port_pkg;
    localparam int OFS_VALUE = 0;   // pad sample on read, whole-latch load on write
    localparam int OFS_SET   = 1;   // write-one-to-set, reads back the latch
    localparam int OFS_CLR   = 2;   // write-one-to-clear, reads as zero
    localparam int OFS_DIR   = 3;   // direction word

    typedef enum logic [2:0] {
        HIT_NONE  = 3'd0,
        HIT_VALUE = 3'd1,
        HIT_SET   = 3'd2,
        HIT_CLR   = 3'd3,
        HIT_DIR   = 3'd4
    } gpio_hit_e;
endpackage

// File: rtl/gpio_bit_order.sv
// Module gpio_bit_order
// Maps a word between register bit order and line order. When MIRROR is 1,
// bit i is swapped with bit WIDTH-1-i; otherwise the word passes unchanged.
// The mapping is its own inverse, so one module serves both directions.
module gpio_bit_order #(
    parameter int WIDTH  = 32,
    parameter bit MIRROR = 1'b0
) (
    input  logic [WIDTH-1:0] src,
    output logic [WIDTH-1:0] dst
);
    // Pick the mapping at elaboration time.
    generate
        if (MIRROR) begin : g_mirror
            for (genvar i = 0; i < WIDTH; i++) begin : g_bit
                assign dst[i] = src[WIDTH-1-i];
            end
        end else begin : g_straight
            assign dst = src;
        end
    endgenerate
endmodule

// File: rtl/gpio_in_sync.sv
// Module gpio_in_sync
// Two-flop synchroniser for the pad inputs, one chain per line.
// It assumes pad_in is asynchronous to clk and that each line is
// independent (no multi-bit coherence is promised).
module gpio_in_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_sync
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;
    logic [1:0]       warm_q;

    // Shift the pad levels through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= pad_in;
            stage2_q <= stage1_q;
        end
    end

    // Count cycles since reset so the delay check starts when history exists.
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assign pad_sync = stage2_q;

    // R7
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (pad_sync == $past(pad_in, 2)))
        else $error("sync_delay_chk");
endmodule

// File: rtl/gpio_port_regs.sv
// Module gpio_port_regs
// Register file of the port, working entirely in line order: output latch,
// direction word, write decode and read mux. It assumes the caller has
// already mapped write data into line order and will map read data back.
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH         = 32,
    parameter int ADDR_W        = 4,
    parameter bit DIR_IS_OUTPUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WIDTH-1:0]  wdata_lines,
    input  logic [WIDTH-1:0]  pad_sync,
    output logic [WIDTH-1:0]  rdata_lines,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  oe
);
    localparam logic [WIDTH-1:0] DIR_RESET = DIR_IS_OUTPUT ? '0 : '1;

    gpio_hit_e        hit;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] set_mask;
    logic [WIDTH-1:0] clr_mask;
    logic [WIDTH-1:0] latch_d;

    // Decode the word offset into one register hit.
    always_comb begin
        if      (addr == ADDR_W'(OFS_VALUE)) hit = HIT_VALUE;
        else if (addr == ADDR_W'(OFS_SET))   hit = HIT_SET;
        else if (addr == ADDR_W'(OFS_CLR))   hit = HIT_CLR;
        else if (addr == ADDR_W'(OFS_DIR))   hit = HIT_DIR;
        else                                 hit = HIT_NONE;
    end

    // Build the next latch value; clear is applied after set so it wins.
    always_comb begin
        set_mask = (we && hit == HIT_SET) ? wdata_lines : '0;
        clr_mask = (we && hit == HIT_CLR) ? wdata_lines : '0;
        if (we && hit == HIT_VALUE) latch_d = wdata_lines;
        else                        latch_d = (latch_q | set_mask) & ~clr_mask;
    end

    // Hold the output latch.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end

    // Hold the direction word.
    always_ff @(posedge clk) begin
        if (!rst_n)                     dir_q <= DIR_RESET;
        else if (we && hit == HIT_DIR)  dir_q <= wdata_lines;
    end

    // Apply the selected direction polarity to the pad enables.
    generate
        if (DIR_IS_OUTPUT) begin : g_dir_out
            assign oe = dir_q;
        end else begin : g_dir_in
            assign oe = ~dir_q;
        end
    endgenerate

    // Select read data for the addressed word.
    always_comb begin
        unique case (hit)
            HIT_VALUE: rdata_lines = pad_sync;
            HIT_SET:   rdata_lines = latch_q;
            HIT_DIR:   rdata_lines = dir_q;
            default:   rdata_lines = '0;
        endcase
    end

    // R3
    value_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit == HIT_VALUE) |=> (latch_q == $past(wdata_lines)))
        else $error("value_load_chk");

    // R4
    set_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit == HIT_SET) |=>
            (latch_q == ($past(latch_q) | $past(wdata_lines))))
        else $error("set_only_chk");

    // R5
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit == HIT_CLR) |=>
            (latch_q == ($past(latch_q) & ~$past(wdata_lines))))
        else $error("clr_only_chk");

    // R10
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit == HIT_NONE) |=> ($stable(latch_q) && $stable(dir_q)))
        else $error("unmapped_write_chk");
endmodule

// File: rtl/gpio_port_ctrl.sv
// Module gpio_port_ctrl
// Top of the I/O port: bit-order mapping on the bus side, register file,
// and input synchroniser. Assumes a single-cycle bus with one access per
// cycle and pads that take pad_out only where pad_oe is 1.
module gpio_port_ctrl #(
    parameter int WIDTH         = 32,
    parameter int ADDR_W        = 4,
    parameter bit DIR_IS_OUTPUT = 1'b1,
    parameter bit MIRROR        = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic [WIDTH-1:0] wdata_lines;
    logic [WIDTH-1:0] rdata_lines;
    logic [WIDTH-1:0] pad_sync;

    // Bus write data into line order.
    gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_wr_order (
        .src (bus_wdata),
        .dst (wdata_lines)
    );

    // Pad inputs into the clock domain.
    gpio_in_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pad_sync (pad_sync)
    );

    // Latch, direction and read mux.
    gpio_port_regs #(
        .WIDTH         (WIDTH),
        .ADDR_W        (ADDR_W),
        .DIR_IS_OUTPUT (DIR_IS_OUTPUT)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (bus_addr),
        .we          (bus_we),
        .wdata_lines (wdata_lines),
        .pad_sync    (pad_sync),
        .rdata_lines (rdata_lines),
        .latch_q     (pad_out),
        .oe          (pad_oe)
    );

    // Read data back into register bit order.
    gpio_bit_order #(.WIDTH(WIDTH), .MIRROR(MIRROR)) u_rd_order (
        .src (rdata_lines),
        .dst (bus_rdata)
    );
endmodule

// File: tb/gpio_port_ctrl_tb.sv
// Directed bench: one task per scenario on a straight 32-bit port with
// output-polarity direction, plus a mirrored 8-bit port with input polarity.
module gpio_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    int          total = 0;
    int          bad = 0;

    logic [3:0]  a_addr = '0;
    logic        a_we = 1'b0;
    logic [31:0] a_wdata = '0;
    logic [31:0] a_rdata;
    logic [31:0] a_pin = '0;
    logic [31:0] a_pout;
    logic [31:0] a_oe;

    logic [3:0]  m_addr = '0;
    logic        m_we = 1'b0;
    logic [7:0]  m_wdata = '0;
    logic [7:0]  m_rdata;
    logic [7:0]  m_pin = '0;
    logic [7:0]  m_pout;
    logic [7:0]  m_oe;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.WIDTH(32), .ADDR_W(4), .DIR_IS_OUTPUT(1'b1), .MIRROR(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(a_addr), .bus_we(a_we),
        .bus_wdata(a_wdata), .bus_rdata(a_rdata), .pad_in(a_pin),
        .pad_out(a_pout), .pad_oe(a_oe));

    gpio_port_ctrl #(.WIDTH(8), .ADDR_W(4), .DIR_IS_OUTPUT(1'b0), .MIRROR(1'b1)) u_dut_mir (
        .clk(clk), .rst_n(rst_n), .bus_addr(m_addr), .bus_we(m_we),
        .bus_wdata(m_wdata), .bus_rdata(m_rdata), .pad_in(m_pin),
        .pad_out(m_pout), .pad_oe(m_oe));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_a(input logic [3:0] ad, input logic [31:0] d);
        @(negedge clk); a_addr = ad; a_we = 1'b1; a_wdata = d;
        @(negedge clk); a_we = 1'b0;
    endtask

    task automatic rd_a(input logic [3:0] ad, output logic [31:0] d);
        @(negedge clk); a_addr = ad; #1 d = a_rdata;
    endtask

    task automatic wr_m(input logic [3:0] ad, input logic [7:0] d);
        @(negedge clk); m_addr = ad; m_we = 1'b1; m_wdata = d;
        @(negedge clk); m_we = 1'b0;
    endtask

    task automatic rd_m(input logic [3:0] ad, output logic [7:0] d);
        @(negedge clk); m_addr = ad; #1 d = m_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] r;
        logic [7:0]  rm;
        check("R2 pad_out after reset", a_pout, 0);
        check("R2 pad_oe after reset", a_oe, 0);
        rd_a(4'd3, r); check("R2 dir reads zero (output polarity)", r, 0);
        rd_a(4'd1, r); check("R2 latch readback zero", r, 0);
        check("R2 mirrored pad_oe after reset", m_oe, 0);
        rd_m(4'd3, rm); check("R2 dir reads ones (input polarity)", rm, 8'hFF);
    endtask

    task automatic t_latch();
        logic [31:0] r;
        wr_a(4'd0, 32'hA5A5_0F0F);
        check("R3 whole latch load", a_pout, 32'hA5A5_0F0F);
        rd_a(4'd1, r); check("R6 set word reads latch", r, 32'hA5A5_0F0F);
        wr_a(4'd1, 32'h0000_F0F0);
        check("R4 set ones, keep zeros", a_pout, 32'hA5A5_FFFF);
        wr_a(4'd2, 32'hA5A5_0000);
        check("R5 clear ones, keep zeros", a_pout, 32'h0000_FFFF);
        rd_a(4'd1, r); check("R6 readback after clear", r, 32'h0000_FFFF);
        rd_a(4'd2, r); check("R10 clear word reads zero", r, 0);
    endtask

    task automatic t_dir();
        logic [31:0] r;
        wr_a(4'd3, 32'hFFFF_0000);
        check("R8 oe follows dir (1=output)", a_oe, 32'hFFFF_0000);
        rd_a(4'd3, r); check("R8 dir readback", r, 32'hFFFF_0000);
    endtask

    task automatic t_sync();
        logic [31:0] r;
        @(negedge clk); a_addr = 4'd0; a_pin = 32'h1234_5678;
        @(negedge clk); check("R7 not visible after one edge", a_rdata, 0);
        @(negedge clk); check("R7 visible after two edges", a_rdata, 32'h1234_5678);
        rd_a(4'd0, r); check("R7 value read stable", r, 32'h1234_5678);
    endtask

    task automatic t_unmapped();
        logic [31:0] r;
        wr_a(4'd4, 32'hFFFF_FFFF);
        wr_a(4'd15, 32'h0000_0000);
        check("R10 latch untouched by unmapped write", a_pout, 32'h0000_FFFF);
        check("R10 oe untouched by unmapped write", a_oe, 32'hFFFF_0000);
        rd_a(4'd4, r); check("R10 offset 4 reads zero", r, 0);
        rd_a(4'd9, r); check("R10 offset 9 reads zero", r, 0);
    endtask

    task automatic t_mirror();
        logic [7:0] rm;
        wr_m(4'd1, 8'h01);
        check("R9 bit0 drives line 7", m_pout, 8'h80);
        rd_m(4'd1, rm); check("R9 latch reads back in bit order", rm, 8'h01);
        wr_m(4'd3, 8'h7F);
        check("R8 R9 dir bit7=0 enables line 0", m_oe, 8'h01);
        wr_m(4'd2, 8'h01);
        check("R9 clear bit0 drops line 7", m_pout, 8'h00);
        m_pin = 8'h01;
        repeat (3) @(negedge clk);
        rd_m(4'd0, rm); check("R9 line 0 pad reads in bit 7", rm, 8'h80);
        wr_m(4'd0, 8'hC0);
        check("R1 R9 8-bit width value load mirrored", m_pout, 8'h03);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_latch();
        t_dir();
        t_sync();
        t_unmapped();
        t_mirror();
        check("R1 32-bit width full latch", a_pout, 32'h0000_FFFF);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule